// File: doc/BRIEF.md
# Paired Output Compare Action Unit

This block drives the two complementary output-compare pins of one motor phase: a high-side pin and a low-side pin. Each side compares an external 16-bit up/down counter against its active compare value. On every clock the block works out the counter phase from the zero strobe, the peak strobe and the count direction. It then picks a 2-bit action for each pin from that side's mode word and applies it on the next edge. The high-side action depends only on the high-side match. The low-side action comes from a 32-bit table indexed by the phase and by the match state of both sides, so the low pin can react to the high pin's compare event.

Each side also keeps a sticky compare flag and an interrupt line gated by an enable. Each side can be switched off. While a side is off its pin follows a software-chosen static level, and that level can be read back at the pin. The counter, its strobes and the double-buffering of the compare and mode registers sit outside the block. The counter is expected to change by at most one count per clock.

Top module: `oc_phase_pair`

## Requirements
- R1: While rst_ni is low, both pins, both flags and both interrupt lines are 0.
- R2: Action codes: 0 hold, 1 drive high, 2 drive low, 3 invert. The chosen action is visible on the pin one clock after the inputs are presented.
- R3: The phase is zero when zero_strobe_i is 1, whatever the other strobes say. Otherwise it is peak when peak_strobe_i is 1. Otherwise it is up when count_up_i is 1, and down when it is 0.
- R4: High-side action fields in mode_hi_i: zero with match 11:10, zero without match 15:14, up with match 9:8, peak with match 7:6, peak without match 13:12, down with match 5:4. A non-match while counting up or down holds the pin.
- R5: Low-side action fields in mode_lo_i at zero and peak, written as (both match / low only / high only / neither): zero 27:26 / 11:10 / 31:30 / 15:14, peak 23:22 / 7:6 / 29:28 / 13:12.
- R6: Low-side fields while counting, with the same order: up 25:24 / 9:8 / 19:18, down 21:20 / 5:4 / 17:16. When neither side matches while counting, the low pin holds.
- R7: A side matches when the count equals its compare value. When its extended-match input is 1, it also matches in the peak phase if the compare value is above the count. In the up and down phases the extended-match input changes nothing.
- R8: While a side's enable is 0, its pin takes that side's port level one clock later and its flag is never set.
- R9: Flag-set enables are in bits 3 (zero), 2 (up), 1 (peak) and 0 (down) of each mode word. An enabled side that matches with the bit for the current phase set raises its flag one clock later. The flag stays set until a clear pulse, and a set in the same cycle as a clear wins.
- R10: Each interrupt line is 1 exactly when its flag is 1 and its interrupt enable is 1.
- R11: An enabled pin does not change after a cycle in the up or down phase in which neither side matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 16 | Counter value |
| count_up_i | input | 1 | Count direction, 1 = up |
| zero_strobe_i | input | 1 | Counter is at zero |
| peak_strobe_i | input | 1 | Counter is at peak |
| cmp_hi_i | input | 16 | High-side active compare value |
| cmp_lo_i | input | 16 | Low-side active compare value |
| mode_hi_i | input | 16 | High-side action and flag-enable word |
| mode_lo_i | input | 32 | Low-side action table and flag-enable word |
| ext_hi_i | input | 1 | High-side extended match enable |
| ext_lo_i | input | 1 | Low-side extended match enable |
| en_hi_i | input | 1 | High-side compare enable |
| en_lo_i | input | 1 | Low-side compare enable |
| lvl_hi_i | input | 1 | High-side static level while disabled |
| lvl_lo_i | input | 1 | Low-side static level while disabled |
| irq_en_hi_i | input | 1 | High-side interrupt enable |
| irq_en_lo_i | input | 1 | Low-side interrupt enable |
| clr_hi_i | input | 1 | High-side flag clear |
| clr_lo_i | input | 1 | Low-side flag clear |
| pin_hi_o | output | 1 | High-side compare pin |
| pin_lo_o | output | 1 | Low-side compare pin |
| flag_hi_o | output | 1 | High-side compare flag |
| flag_lo_o | output | 1 | Low-side compare flag |
| irq_hi_o | output | 1 | High-side interrupt |
| irq_lo_o | output | 1 | Low-side interrupt |

## Verification
The assertions watch the cycle-local rules on every clock: a disabled pin copies its port level, a pin stays put through a counting cycle with no match, interrupts follow flag and enable, and flags only rise on an enabled side. Which table field drives a pin for a given phase and match pair, the encoding of the four actions, the strobe priority and the extended match at turnaround can only be shown by the bench. The bench sweeps every phase, match pair, starting level and several field patterns, and computes the expected pin from the bit positions in the requirements.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int HI_MODE_W = 16;
  localparam int LO_MODE_W = 32;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_LOW  = 2'd2,
    ACT_INV  = 2'd3
  } act_e;

  // encoding chosen so that the flag-enable bit index is 3 - phase
  typedef enum logic [1:0] {
    PH_ZERO = 2'd0,
    PH_UP   = 2'd1,
    PH_PEAK = 2'd2,
    PH_DOWN = 2'd3
  } phase_e;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_HIGH: return 1'b1;
      ACT_LOW:  return 1'b0;
      ACT_INV:  return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/ocp_phase_decode.sv
module ocp_phase_decode import ocp_pkg::*; (
  input  logic       zero_i,
  input  logic       peak_i,
  input  logic       up_i,
  output phase_e     phase_o,
  output logic [1:0] fbit_o
);
  always_comb begin
    if (zero_i)      phase_o = PH_ZERO;
    else if (peak_i) phase_o = PH_PEAK;
    else if (up_i)   phase_o = PH_UP;
    else             phase_o = PH_DOWN;
    fbit_o = 2'd3 - phase_o;
  end
endmodule

// File: rtl/ocp_match.sv
module ocp_match import ocp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  phase_e           phase_i,
  input  logic             ext_i,
  output logic             hit_o
);
  logic eq, past_turn;
  assign eq        = (cnt_i == cmp_i);
  // counter turned around below the compare value: do not lose the event
  assign past_turn = ext_i && (phase_i == PH_PEAK) && (cmp_i > cnt_i);
  assign hit_o     = eq | past_turn;
endmodule

// File: rtl/ocp_hi_select.sv
module ocp_hi_select import ocp_pkg::*; (
  input  logic [HI_MODE_W-1:0] mode_i,
  input  phase_e               phase_i,
  input  logic [1:0]           fbit_i,
  input  logic                 hit_i,
  output act_e                 act_o,
  output logic                 fset_o
);
  logic [1:0] code;
  always_comb begin
    code = 2'd0;
    case (phase_i)
      PH_ZERO: code = hit_i ? mode_i[11:10] : mode_i[15:14];
      PH_UP:   code = hit_i ? mode_i[9:8]   : 2'd0;
      PH_PEAK: code = hit_i ? mode_i[7:6]   : mode_i[13:12];
      PH_DOWN: code = hit_i ? mode_i[5:4]   : 2'd0;
      default: code = 2'd0;
    endcase
  end
  assign act_o  = act_e'(code);
  assign fset_o = hit_i & mode_i[fbit_i];
endmodule

// File: rtl/ocp_lo_select.sv
module ocp_lo_select import ocp_pkg::*; (
  input  logic [LO_MODE_W-1:0] mode_i,
  input  phase_e               phase_i,
  input  logic [1:0]           fbit_i,
  input  logic                 hit_hi_i,
  input  logic                 hit_lo_i,
  output act_e                 act_o,
  output logic                 fset_o
);
  logic [1:0] code;
  logic [1:0] pair;
  assign pair = {hit_hi_i, hit_lo_i};

  always_comb begin
    code = 2'd0;
    case (phase_i)
      PH_ZERO: case (pair)
        2'b11:   code = mode_i[27:26];
        2'b01:   code = mode_i[11:10];
        2'b10:   code = mode_i[31:30];
        default: code = mode_i[15:14];
      endcase
      PH_UP: case (pair)
        2'b11:   code = mode_i[25:24];
        2'b01:   code = mode_i[9:8];
        2'b10:   code = mode_i[19:18];
        default: code = 2'd0;
      endcase
      PH_PEAK: case (pair)
        2'b11:   code = mode_i[23:22];
        2'b01:   code = mode_i[7:6];
        2'b10:   code = mode_i[29:28];
        default: code = mode_i[13:12];
      endcase
      default: case (pair)
        2'b11:   code = mode_i[21:20];
        2'b01:   code = mode_i[5:4];
        2'b10:   code = mode_i[17:16];
        default: code = 2'd0;
      endcase
    endcase
  end
  assign act_o  = act_e'(code);
  assign fset_o = hit_lo_i & mode_i[fbit_i];
endmodule

// File: rtl/ocp_out_cell.sv
module ocp_out_cell import ocp_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  act_e act_i,
  input  logic fset_i,
  input  logic clr_i,
  output logic pin_o,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o  <= 1'b0;
      flag_o <= 1'b0;
    end else if (!en_i) begin
      pin_o  <= lvl_i;
      flag_o <= flag_o & ~clr_i;
    end else begin
      pin_o  <= apply_act(act_i, pin_o);
      flag_o <= fset_i | (flag_o & ~clr_i);
    end
  end
endmodule

// File: rtl/oc_phase_pair.sv
module oc_phase_pair import ocp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 count_up_i,
  input  logic                 zero_strobe_i,
  input  logic                 peak_strobe_i,
  input  logic [CNT_W-1:0]     cmp_hi_i,
  input  logic [CNT_W-1:0]     cmp_lo_i,
  input  logic [HI_MODE_W-1:0] mode_hi_i,
  input  logic [LO_MODE_W-1:0] mode_lo_i,
  input  logic                 ext_hi_i,
  input  logic                 ext_lo_i,
  input  logic                 en_hi_i,
  input  logic                 en_lo_i,
  input  logic                 lvl_hi_i,
  input  logic                 lvl_lo_i,
  input  logic                 irq_en_hi_i,
  input  logic                 irq_en_lo_i,
  input  logic                 clr_hi_i,
  input  logic                 clr_lo_i,
  output logic                 pin_hi_o,
  output logic                 pin_lo_o,
  output logic                 flag_hi_o,
  output logic                 flag_lo_o,
  output logic                 irq_hi_o,
  output logic                 irq_lo_o
);
  localparam int SIDES = 2;
  localparam int HI = 0;
  localparam int LO = 1;

  phase_e     phase;
  logic [1:0] fbit;

  logic [CNT_W-1:0] cmp_v [SIDES];
  logic [SIDES-1:0] ext_v, en_v, lvl_v, clr_v, irq_en_v;
  logic [SIDES-1:0] hit, fset, pin_q, flag_q;
  act_e             act_v [SIDES];

  assign cmp_v[HI] = cmp_hi_i;
  assign cmp_v[LO] = cmp_lo_i;
  assign ext_v     = {ext_lo_i, ext_hi_i};
  assign en_v      = {en_lo_i, en_hi_i};
  assign lvl_v     = {lvl_lo_i, lvl_hi_i};
  assign clr_v     = {clr_lo_i, clr_hi_i};
  assign irq_en_v  = {irq_en_lo_i, irq_en_hi_i};

  ocp_phase_decode u_phase (
    .zero_i  (zero_strobe_i),
    .peak_i  (peak_strobe_i),
    .up_i    (count_up_i),
    .phase_o (phase),
    .fbit_o  (fbit)
  );

  ocp_hi_select u_hi_sel (
    .mode_i  (mode_hi_i),
    .phase_i (phase),
    .fbit_i  (fbit),
    .hit_i   (hit[HI]),
    .act_o   (act_v[HI]),
    .fset_o  (fset[HI])
  );

  ocp_lo_select u_lo_sel (
    .mode_i   (mode_lo_i),
    .phase_i  (phase),
    .fbit_i   (fbit),
    .hit_hi_i (hit[HI]),
    .hit_lo_i (hit[LO]),
    .act_o    (act_v[LO]),
    .fset_o   (fset[LO])
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ocp_match #(.CNT_W(CNT_W)) u_match (
      .cnt_i   (count_i),
      .cmp_i   (cmp_v[s]),
      .phase_i (phase),
      .ext_i   (ext_v[s]),
      .hit_o   (hit[s])
    );

    ocp_out_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_v[s]),
      .lvl_i  (lvl_v[s]),
      .act_i  (act_v[s]),
      .fset_i (fset[s]),
      .clr_i  (clr_v[s]),
      .pin_o  (pin_q[s]),
      .flag_o (flag_q[s])
    );
  end

  assign pin_hi_o  = pin_q[HI];
  assign pin_lo_o  = pin_q[LO];
  assign flag_hi_o = flag_q[HI];
  assign flag_lo_o = flag_q[LO];
  assign irq_hi_o  = flag_q[HI] & irq_en_v[HI];
  assign irq_lo_o  = flag_q[LO] & irq_en_v[LO];
endmodule

// File: rtl/ocp_checker.sv
module ocp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             zero_strobe_i,
  input logic             peak_strobe_i,
  input logic [CNT_W-1:0] cmp_hi_i,
  input logic [CNT_W-1:0] cmp_lo_i,
  input logic             en_hi_i,
  input logic             en_lo_i,
  input logic             lvl_hi_i,
  input logic             lvl_lo_i,
  input logic             irq_en_hi_i,
  input logic             irq_en_lo_i,
  input logic             pin_hi_o,
  input logic             pin_lo_o,
  input logic             flag_hi_o,
  input logic             flag_lo_o,
  input logic             irq_hi_o,
  input logic             irq_lo_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!pin_hi_o && !pin_lo_o && !flag_hi_o && !flag_lo_o);
    end
  end

  assert_hi_port_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_hi_i |=> pin_hi_o == $past(lvl_hi_i));
  assert_lo_port_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lo_i |=> pin_lo_o == $past(lvl_lo_i));

  assert_hi_flag_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_hi_i && !flag_hi_o |=> !flag_hi_o);
  assert_lo_flag_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lo_i && !flag_lo_o |=> !flag_lo_o);

  assert_hi_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> flag_hi_o && irq_en_hi_i);
  assert_lo_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> flag_lo_o && irq_en_lo_i);

  assert_hi_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_hi_i && !zero_strobe_i && !peak_strobe_i && count_i != cmp_hi_i
    |=> $stable(pin_hi_o));
  assert_lo_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_lo_i && !zero_strobe_i && !peak_strobe_i && count_i != cmp_hi_i && count_i != cmp_lo_i
    |=> $stable(pin_lo_o));
endmodule

bind oc_phase_pair ocp_checker #(.CNT_W(CNT_W)) i_ocp_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .count_i       (count_i),
  .zero_strobe_i (zero_strobe_i),
  .peak_strobe_i (peak_strobe_i),
  .cmp_hi_i      (cmp_hi_i),
  .cmp_lo_i      (cmp_lo_i),
  .en_hi_i       (en_hi_i),
  .en_lo_i       (en_lo_i),
  .lvl_hi_i      (lvl_hi_i),
  .lvl_lo_i      (lvl_lo_i),
  .irq_en_hi_i   (irq_en_hi_i),
  .irq_en_lo_i   (irq_en_lo_i),
  .pin_hi_o      (pin_hi_o),
  .pin_lo_o      (pin_lo_o),
  .flag_hi_o     (flag_hi_o),
  .flag_lo_o     (flag_lo_o),
  .irq_hi_o      (irq_hi_o),
  .irq_lo_o      (irq_lo_o)
);

// File: tb/test_oc_phase_pair.sv
`timescale 1ns/1ps
module test_oc_phase_pair;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] count_i = '0;
  logic        count_up_i = 1'b1;
  logic        zero_strobe_i = 1'b0;
  logic        peak_strobe_i = 1'b0;
  logic [15:0] cmp_hi_i = 16'd1000;
  logic [15:0] cmp_lo_i = 16'd1000;
  logic [15:0] mode_hi_i = '0;
  logic [31:0] mode_lo_i = '0;
  logic        ext_hi_i = 1'b0, ext_lo_i = 1'b0;
  logic        en_hi_i = 1'b0, en_lo_i = 1'b0;
  logic        lvl_hi_i = 1'b0, lvl_lo_i = 1'b0;
  logic        irq_en_hi_i = 1'b0, irq_en_lo_i = 1'b0;
  logic        clr_hi_i = 1'b0, clr_lo_i = 1'b0;
  logic        pin_hi_o, pin_lo_o, flag_hi_o, flag_lo_o, irq_hi_o, irq_lo_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  oc_phase_pair i_oc_phase_pair (.*);

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic app(input logic [1:0] c, input logic cur);
    case (c)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  // field LSB from R4; -1 means hold
  function automatic int hi_pos(input int ph, input bit hh);
    case (ph)
      0: return hh ? 10 : 14;
      1: return hh ? 8 : -1;
      2: return hh ? 6 : 12;
      default: return hh ? 4 : -1;
    endcase
  endfunction

  // field LSB from R5 / R6
  function automatic int lo_pos(input int ph, input bit hh, input bit hl);
    int t[4][4];
    t[0] = '{14, 10, 30, 26};
    t[1] = '{-1, 8, 18, 24};
    t[2] = '{12, 6, 28, 22};
    t[3] = '{-1, 4, 16, 20};
    return t[ph][{hh, hl}];
  endfunction

  // phase 0 zero, 1 up, 2 peak, 3 down; zero/peak driven with count_up_i=1 (R3)
  task automatic set_phase(input int ph, input bit hh, input bit hl);
    zero_strobe_i = (ph == 0);
    peak_strobe_i = (ph == 2);
    count_up_i    = (ph != 3);
    case (ph)
      0: begin count_i = 16'd0;   cmp_hi_i = hh ? 16'd0 : 16'd7;    cmp_lo_i = hl ? 16'd0 : 16'd9;   end
      2: begin count_i = 16'd100; cmp_hi_i = hh ? 16'd100 : 16'd60; cmp_lo_i = hl ? 16'd100 : 16'd61; end
      default: begin count_i = 16'd40; cmp_hi_i = hh ? 16'd40 : 16'd44; cmp_lo_i = hl ? 16'd40 : 16'd45; end
    endcase
  endtask

  task automatic neutral();
    zero_strobe_i = 1'b0; peak_strobe_i = 1'b0; count_up_i = 1'b1;
    count_i = 16'd40; cmp_hi_i = 16'd1000; cmp_lo_i = 16'd1000;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h1B4E_93D6;
    pats[1] = 32'hE4B1_6C29;
    pats[2] = 32'h72D8_A5C3;

    // R1
    repeat (2) @(negedge clk_i);
    chk(pin_hi_o, 1'b0, "R1", "pin_hi in reset");
    chk(pin_lo_o, 1'b0, "R1", "pin_lo in reset");
    chk(flag_hi_o | flag_lo_o, 1'b0, "R1", "flags in reset");
    chk(irq_hi_o | irq_lo_o, 1'b0, "R1", "irqs in reset");
    rst_ni = 1'b1;
    tick();

    // R2 R3 R4 R5 R6: sweep phase x match pair x start level x field pattern
    for (int pv = 0; pv < 7; pv++) begin
      for (int ph = 0; ph < 4; ph++) begin
        for (int m = 0; m < 4; m++) begin
          for (int init = 0; init < 2; init++) begin
            logic [31:0] lw;
            bit hh, hl;
            int ph_, pl_;
            logic eh, el;
            hh = m[1]; hl = m[0];
            lw = (pv < 4) ? {16{pv[1:0]}} : pats[pv-4];
            en_hi_i = 1'b0; en_lo_i = 1'b0;
            lvl_hi_i = init[0]; lvl_lo_i = init[0];
            neutral();
            tick();
            mode_hi_i = lw[15:0] ^ lw[31:16];
            mode_lo_i = lw;
            en_hi_i = 1'b1; en_lo_i = 1'b1;
            set_phase(ph, hh, hl);
            tick();
            ph_ = hi_pos(ph, hh);
            pl_ = lo_pos(ph, hh, hl);
            eh = (ph_ < 0) ? init[0] : app(mode_hi_i[ph_ +: 2], init[0]);
            el = (pl_ < 0) ? init[0] : app(mode_lo_i[pl_ +: 2], init[0]);
            chk(pin_hi_o, eh, "R4", $sformatf("hi ph=%0d m=%0d init=%0d pv=%0d", ph, m, init, pv));
            chk(pin_lo_o, el, (pl_ < 0) ? "R6" : "R5",
                $sformatf("lo ph=%0d m=%0d init=%0d pv=%0d", ph, m, init, pv));
          end
        end
      end
    end

    // R7: extended match at peak with compare above count
    for (int e = 0; e < 2; e++) begin
      en_hi_i = 1'b0; lvl_hi_i = 1'b0; neutral(); tick();
      mode_hi_i = 16'h2040;  // peak match -> high (7:6=1), peak no match -> low (13:12=2)
      en_hi_i = 1'b1; ext_hi_i = e[0];
      zero_strobe_i = 1'b0; peak_strobe_i = 1'b1; count_i = 16'd100; cmp_hi_i = 16'd120;
      tick();
      chk(pin_hi_o, e[0], "R7", $sformatf("peak turnaround ext=%0d", e));
    end
    // R7: extended option is inert while counting up
    en_hi_i = 1'b0; lvl_hi_i = 1'b0; neutral(); tick();
    mode_hi_i = 16'h0300; en_hi_i = 1'b1; ext_hi_i = 1'b1;
    count_i = 16'd40; cmp_hi_i = 16'd45; tick();
    chk(pin_hi_o, 1'b0, "R7", "ext during up no match");
    ext_hi_i = 1'b0;

    // R8: disabled side ignores a matching action, follows port level
    en_lo_i = 1'b0; lvl_lo_i = 1'b1; mode_lo_i = 32'hFFFF_FFFF; clr_lo_i = 1'b1;
    set_phase(1, 1'b1, 1'b1); tick();
    clr_lo_i = 1'b0; tick();
    chk(pin_lo_o, 1'b1, "R8", "disabled lo pin follows level");
    chk(flag_lo_o, 1'b0, "R8", "disabled lo flag not set");
    lvl_lo_i = 1'b0; tick();
    chk(pin_lo_o, 1'b0, "R8", "disabled lo pin level change");

    // R9 R10: flag enable bits per phase, both sides
    for (int ph = 0; ph < 4; ph++) begin
      for (int b = 0; b < 2; b++) begin
        en_hi_i = 1'b1; en_lo_i = 1'b1; neutral();
        clr_hi_i = 1'b1; clr_lo_i = 1'b1; tick();
        clr_hi_i = 1'b0; clr_lo_i = 1'b0;
        mode_hi_i = b ? (16'd1 << (3 - ph)) : (16'h000F & ~(16'd1 << (3 - ph)));
        mode_lo_i = {16'h0, mode_hi_i};
        irq_en_hi_i = b[0]; irq_en_lo_i = 1'b0;
        set_phase(ph, 1'b1, 1'b1); tick();
        chk(flag_hi_o, b[0], "R9", $sformatf("hi flag ph=%0d bit=%0d", ph, b));
        chk(flag_lo_o, b[0], "R9", $sformatf("lo flag ph=%0d bit=%0d", ph, b));
        chk(irq_hi_o, b[0], "R10", $sformatf("hi irq ph=%0d", ph));
        chk(irq_lo_o, 1'b0, "R10", $sformatf("lo irq masked ph=%0d", ph));
      end
    end
    // R9: sticky, set wins over clear, clear alone clears
    mode_hi_i = 16'h0004; mode_lo_i = 32'h4;
    set_phase(1, 1'b1, 1'b1); tick();
    neutral(); tick(); tick();
    chk(flag_hi_o, 1'b1, "R9", "flag sticky");
    set_phase(1, 1'b1, 1'b0); clr_hi_i = 1'b1; clr_lo_i = 1'b1; tick();
    chk(flag_hi_o, 1'b1, "R9", "set beats clear");
    chk(flag_lo_o, 1'b0, "R9", "clear without set");
    neutral(); tick();
    chk(flag_hi_o, 1'b0, "R9", "clear alone");
    clr_hi_i = 1'b0; clr_lo_i = 1'b0;
    irq_en_lo_i = 1'b1; tick();
    chk(irq_lo_o, 1'b0, "R10", "irq needs flag");

    // R11: counting without a match holds both pins
    en_hi_i = 1'b0; en_lo_i = 1'b0; lvl_hi_i = 1'b1; lvl_lo_i = 1'b0; tick();
    mode_hi_i = 16'hFFFF; mode_lo_i = 32'hFFFF_FFFF; en_hi_i = 1'b1; en_lo_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      count_up_i = k[0]; count_i = 16'(50 + k); tick();
      chk(pin_hi_o, 1'b1, "R11", $sformatf("hi hold step %0d", k));
      chk(pin_lo_o, 1'b0, "R11", $sformatf("lo hold step %0d", k));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule